// File: doc/BRIEF.md
# TDM Timeslot-Selective Serial Port

This block connects to a shared time-division multiplexed serial bus, of the kind used to carry 24-channel or 32-channel digitised voice trunks. The bus has a bit clock, a frame sync pulse and one data line in each direction. A frame is made of 8-bit slots. A host writes a 32-bit ownership mask, with one bit per slot. The port then listens only to the slots it owns and talks only in those slots.

On the receive side, every owned slot's byte is placed in a single-entry holding register, together with the index of its slot. A consumer reads it with a valid/acknowledge pair. On the transmit side, the port requests one byte at the start of each owned slot and shifts it out. Its output enable is low in every other slot, so a pad can release the line to high impedance. Many ports can share the same lines this way, provided their masks do not overlap.

The TDM signals are asynchronous to the system clock. They are resynchronised and their edges are detected by oversampling, so the system clock must run several times faster than the bit clock. Mask writes are shadowed and take effect at a frame boundary.

Top module: `tdm_slot_port`

## Requirements
- R1: After reset, rxValid, tdmTxOe, txReq, frmErr and rxOverrun are low. Until the first frame sync is seen, no byte is captured and the transmit enable never rises. Transmission begins in the first slot after that sync.
- R2: A frame sync that is high at a falling bit-clock edge marks bit 0 of slot 0. Slot k occupies frame bits 8k to 8k+7. A frame has 24 slots when e1Mode is 0 and 32 slots when e1Mode is 1. Back-to-back frames of the correct length never raise frmErr.
- R3: Receive data is sampled at falling bit-clock edges, most significant bit first. After the eighth bit of an owned slot, that byte appears on rxData with the slot index on rxSlot, and rxValid is high.
- R4: Slots whose mask bit is 0 are never presented. In 24-slot mode, mask bits 24 to 31 have no effect.
- R5: At the rising edge that starts an owned slot, the port pulses txReq with the slot on txReqSlot and takes txByte in that cycle. It drives the byte on tdmTxd, most significant bit first, with one bit per rising edge and tdmTxOe high for the whole slot.
- R6: tdmTxOe is low throughout every slot that is not owned.
- R7: A mask written with maskWr, and the value of e1Mode, take effect from the next frame boundary. The frame in progress keeps the old ownership.
- R8: A frame sync that arrives anywhere other than the expected frame start sets frmErr and realigns slot counting to that sync. frmErr stays set until errClr.
- R9: rxValid, rxData and rxSlot hold until rxAck. A byte that completes while the register is full and not acknowledged is dropped and sets rxOverrun. rxOverrun stays set until errClr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than the bit clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tdmClk | input | 1 | Bus bit clock |
| tdmFsync | input | 1 | Bus frame sync, high during bit 0 of a frame |
| tdmRxd | input | 1 | Bus receive data |
| tdmTxd | output | 1 | Transmit data toward the shared line |
| tdmTxOe | output | 1 | Transmit driver enable; low means the line is released |
| e1Mode | input | 1 | 1 selects 32-slot frames, 0 selects 24-slot frames |
| maskIn | input | 32 | New slot ownership mask, bit k for slot k |
| maskWr | input | 1 | Strobe that loads maskIn into the pending mask |
| rxValid | output | 1 | Holding register contains a byte |
| rxData | output | 8 | Received byte |
| rxSlot | output | 5 | Slot index of the received byte |
| rxAck | input | 1 | Consumer takes the held byte |
| txReq | output | 1 | One-cycle request for the next transmit byte |
| txReqSlot | output | 5 | Slot index of the requested byte |
| txByte | input | 8 | Transmit byte, sampled while txReq is high |
| frmErr | output | 1 | Sticky misplaced frame sync flag |
| rxOverrun | output | 1 | Sticky receive overrun flag |
| errClr | input | 1 | Clears both sticky flags |

## Verification
The bench targets the slot that straddles a mask rewrite: a mask written partway through a frame must leave that frame untouched. A design that applied the write at once would capture or drive a slot that belongs to a neighbour. The mode change between 24-slot and 32-slot frames is also exercised, because a position counter that compared against the new frame length too early would raise a false framing error. The bench checks the highest slot (31) and a mask bit above 23 in 24-slot mode, which catch off-by-one slot decoding. It sends a truncated frame followed by an early sync, and lets two owned bytes arrive with no acknowledge. A port that failed to realign, overwrote the held byte, or cleared a sticky flag by itself would show the wrong data or flag.

// File: rtl/tdm_port_pkg.sv
package tdm_port_pkg;
  parameter int SLOT_BITS = 8;
  parameter int MAX_SLOTS = 32;
  parameter int T1_SLOTS  = 24;
  localparam int BIT_W    = $clog2(SLOT_BITS);
  localparam int SLOT_W   = $clog2(MAX_SLOTS);
  localparam int POS_W    = $clog2(MAX_SLOTS * SLOT_BITS);

  // Strobes from the frame controller to the datapath, valid for one cycle.
  typedef struct packed {
    logic              sampleEn;  // falling edge while aligned: shift rxBit in
    logic              rxBit;     // resynchronised receive bit
    logic              rxDone;    // last bit of an owned slot was just sampled
    logic [SLOT_W-1:0] rxSlot;    // slot of the bit being sampled
    logic              launchEn;  // rising edge while aligned
    logic              txLoad;    // start of an owned slot: fetch byte
    logic              txIdle;    // start of a foreign slot: release line
    logic [BIT_W-1:0]  txBitIdx;  // bit within slot being launched
    logic [SLOT_W-1:0] txSlot;    // slot being launched
  } tdm_strobe_t;
endpackage

// File: rtl/tdm_port_ctrl.sv
module tdm_port_ctrl
  import tdm_port_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 tdmClk,
  input  logic                 tdmFsync,
  input  logic                 tdmRxd,
  input  logic                 e1Mode,
  input  logic [MAX_SLOTS-1:0] maskIn,
  input  logic                 maskWr,
  input  logic                 errClr,
  output tdm_strobe_t          st,
  output logic                 frmErr
);
  localparam logic [POS_W-1:0] LAST_E1 = POS_W'(MAX_SLOTS * SLOT_BITS - 1);
  localparam logic [POS_W-1:0] LAST_T1 = POS_W'(T1_SLOTS * SLOT_BITS - 1);

  logic [SYNC_STAGES-1:0] clkSync, fsSync, rxSync;
  logic                   clkPrev;
  logic                   fallEv, riseEv, fsHit;

  logic                   synced;
  logic                   nextIsZero;
  logic [POS_W-1:0]       pos;
  logic [MAX_SLOTS-1:0]   pendMask, actMask, useMask;
  logic                   actE1;

  logic [POS_W-1:0]       lastPos, rxPos, txPos;
  logic                   frameWrap, slotStart;
  logic [SLOT_W-1:0]      rxSlotIdx, txSlotIdx;
  logic [BIT_W-1:0]       rxBitIdx, txBitIdx;

  // resynchronisers for the asynchronous bus signals
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkSync <= '0;
      fsSync  <= '0;
      rxSync  <= '0;
      clkPrev <= 1'b0;
    end else begin
      clkSync <= {clkSync[SYNC_STAGES-2:0], tdmClk};
      fsSync  <= {fsSync[SYNC_STAGES-2:0], tdmFsync};
      rxSync  <= {rxSync[SYNC_STAGES-2:0], tdmRxd};
      clkPrev <= clkSync[SYNC_STAGES-1];
    end
  end

  assign fallEv = clkPrev & ~clkSync[SYNC_STAGES-1];
  assign riseEv = ~clkPrev & clkSync[SYNC_STAGES-1];
  assign fsHit  = fallEv & fsSync[SYNC_STAGES-1];

  always_comb begin
    lastPos   = actE1 ? LAST_E1 : LAST_T1;
    rxPos     = (fsHit || nextIsZero) ? '0 : pos + 1'b1;
    txPos     = (pos == lastPos) ? '0 : pos + 1'b1;
    rxSlotIdx = rxPos[POS_W-1:BIT_W];
    rxBitIdx  = rxPos[BIT_W-1:0];
    txSlotIdx = txPos[POS_W-1:BIT_W];
    txBitIdx  = txPos[BIT_W-1:0];
    frameWrap = riseEv & synced & (txPos == '0);
    useMask   = frameWrap ? pendMask : actMask;
    slotStart = riseEv & synced & (txBitIdx == '0);
  end

  always_comb begin
    st          = '0;
    st.sampleEn = fallEv & synced;
    st.rxBit    = rxSync[SYNC_STAGES-1];
    st.rxSlot   = rxSlotIdx;
    st.rxDone   = fallEv & synced & (rxBitIdx == BIT_W'(SLOT_BITS - 1))
                  & actMask[rxSlotIdx];
    st.launchEn = riseEv & synced;
    st.txBitIdx = txBitIdx;
    st.txSlot   = txSlotIdx;
    st.txLoad   = slotStart & useMask[txSlotIdx];
    st.txIdle   = slotStart & ~useMask[txSlotIdx];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      synced     <= 1'b0;
      nextIsZero <= 1'b0;
      pos        <= '0;
      pendMask   <= '0;
      actMask    <= '0;
      actE1      <= 1'b0;
      frmErr     <= 1'b0;
    end else begin
      if (maskWr) pendMask <= maskIn;

      // ownership and frame length switch only at a frame boundary
      if (fsHit && !synced) begin
        synced  <= 1'b1;
        actMask <= pendMask;
        actE1   <= e1Mode;
      end else if (frameWrap) begin
        actMask <= pendMask;
        actE1   <= e1Mode;
      end

      if (frameWrap)   nextIsZero <= 1'b1;
      else if (fallEv) nextIsZero <= 1'b0;

      if (fallEv && (synced || fsHit)) pos <= rxPos;

      if (fsHit && synced && !nextIsZero) frmErr <= 1'b1;
      else if (errClr)                    frmErr <= 1'b0;
    end
  end
endmodule

// File: rtl/tdm_port_dp.sv
module tdm_port_dp
  import tdm_port_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  tdm_strobe_t          st,
  input  logic [SLOT_BITS-1:0] txByte,
  input  logic                 rxAck,
  input  logic                 errClr,
  output logic                 rxValid,
  output logic [SLOT_BITS-1:0] rxData,
  output logic [SLOT_W-1:0]    rxSlot,
  output logic                 rxOverrun,
  output logic                 tdmTxd,
  output logic                 tdmTxOe
);
  logic [SLOT_BITS-1:0] rxShift, rxNext;
  logic [SLOT_BITS-1:0] txShift;
  logic                 canLoad;

  assign rxNext  = {rxShift[SLOT_BITS-2:0], st.rxBit};
  assign canLoad = ~rxValid | rxAck;

  // receive shift register and single-entry holding register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift   <= '0;
      rxValid   <= 1'b0;
      rxData    <= '0;
      rxSlot    <= '0;
      rxOverrun <= 1'b0;
    end else begin
      if (st.sampleEn) rxShift <= rxNext;

      if (st.rxDone && canLoad) begin
        rxValid <= 1'b1;
        rxData  <= rxNext;
        rxSlot  <= st.rxSlot;
      end else if (rxAck) begin
        rxValid <= 1'b0;
      end

      if (st.rxDone && !canLoad) rxOverrun <= 1'b1;
      else if (errClr)           rxOverrun <= 1'b0;
    end
  end

  // transmit: fetch at slot start, then one bit per rising edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      tdmTxd  <= 1'b0;
      tdmTxOe <= 1'b0;
    end else if (st.txLoad) begin
      txShift <= txByte;
      tdmTxd  <= txByte[SLOT_BITS-1];
      tdmTxOe <= 1'b1;
    end else if (st.txIdle) begin
      tdmTxd  <= 1'b0;
      tdmTxOe <= 1'b0;
    end else if (st.launchEn && tdmTxOe) begin
      tdmTxd  <= txShift[BIT_W'(SLOT_BITS - 1) - st.txBitIdx];
    end
  end
endmodule

// File: rtl/tdm_slot_port.sv
module tdm_slot_port
  import tdm_port_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        tdmClk,
  input  logic        tdmFsync,
  input  logic        tdmRxd,
  output logic        tdmTxd,
  output logic        tdmTxOe,
  input  logic        e1Mode,
  input  logic [31:0] maskIn,
  input  logic        maskWr,
  output logic        rxValid,
  output logic [7:0]  rxData,
  output logic [4:0]  rxSlot,
  input  logic        rxAck,
  output logic        txReq,
  output logic [4:0]  txReqSlot,
  input  logic [7:0]  txByte,
  output logic        frmErr,
  output logic        rxOverrun,
  input  logic        errClr
);
  tdm_strobe_t st;

  tdm_port_ctrl #(.SYNC_STAGES(2)) u_ctrl (
    .clk(clk), .rstN(rstN), .tdmClk(tdmClk), .tdmFsync(tdmFsync),
    .tdmRxd(tdmRxd), .e1Mode(e1Mode), .maskIn(maskIn), .maskWr(maskWr),
    .errClr(errClr), .st(st), .frmErr(frmErr)
  );

  tdm_port_dp u_dp (
    .clk(clk), .rstN(rstN), .st(st), .txByte(txByte), .rxAck(rxAck),
    .errClr(errClr), .rxValid(rxValid), .rxData(rxData), .rxSlot(rxSlot),
    .rxOverrun(rxOverrun), .tdmTxd(tdmTxd), .tdmTxOe(tdmTxOe)
  );

  assign txReq     = st.txLoad;
  assign txReqSlot = st.txSlot;
endmodule

// File: rtl/tdm_slot_port_chk.sv
module tdm_slot_port_chk
  import tdm_port_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input tdm_strobe_t st,
  input logic        rxValid,
  input logic [7:0]  rxData,
  input logic [4:0]  rxSlot,
  input logic        rxAck,
  input logic        rxOverrun,
  input logic        frmErr,
  input logic        errClr,
  input logic        tdmTxd,
  input logic        tdmTxOe
);
  p_rx_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    rxValid && !rxAck |=> rxValid && $stable(rxData) && $stable(rxSlot));

  p_ovr_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    rxOverrun && !errClr |=> rxOverrun);

  p_frm_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    frmErr && !errClr |=> frmErr);

  p_tx_on_launch_r5: assert property (@(posedge clk) disable iff (!rstN)
    !st.launchEn |=> $stable(tdmTxd) && $stable(tdmTxOe));

  p_rx_on_sample_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxValid) |-> $past(st.sampleEn));

  p_idle_release_r6: assert property (@(posedge clk) disable iff (!rstN)
    st.txIdle |=> !tdmTxOe);
endmodule

bind tdm_slot_port tdm_slot_port_chk u_chk (.*);

// File: tb/tdm_slot_port_bench.sv
module tdm_slot_port_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rstN = 1'b0;
  logic        tdmClk = 1'b0, tdmFsync = 1'b0, tdmRxd = 1'b0;
  logic        tdmTxd, tdmTxOe;
  logic        e1Mode = 1'b0;
  logic [31:0] maskIn = '0;
  logic        maskWr = 1'b0;
  logic        rxValid;
  logic [7:0]  rxData;
  logic [4:0]  rxSlot;
  logic        rxAck = 1'b0;
  logic        txReq;
  logic [4:0]  txReqSlot;
  logic [7:0]  txByte;
  logic        frmErr, rxOverrun;
  logic        errClr = 1'b0;

  tdm_slot_port u_tdm_slot_port (.*);

  function automatic logic [7:0] txPat(input logic [4:0] s);
    return 8'(s) * 8'd29 + 8'h3C;
  endfunction
  function automatic logic [7:0] rxPat(input int s, input int tag);
    return 8'((s * 37 + tag * 11 + 5) & 255);
  endfunction

  assign txByte = txPat(txReqSlot);

  int errors = 0, checks = 0;
  int frameTag = 0;
  bit autoAck = 1'b1;
  int ackReq = 0, ackDone = 0;
  int gotTag[32];
  logic [7:0] gotByte[32];
  logic txOeSeen[256];
  logic txDSeen[256];
  bit done = 1'b0;

  // receive consumer: logs and acknowledges away from the active edge
  always @(negedge clk) begin
    if (rxAck) rxAck = 1'b0;
    else if (rxValid && (autoAck || ackReq != ackDone)) begin
      if (autoAck) begin
        gotTag[rxSlot]  = frameTag;
        gotByte[rxSlot] = rxData;
      end
      if (ackReq != ackDone) ackDone++;
      rxAck = 1'b1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic writeMask(input logic [31:0] m);
    maskIn = m; maskWr = 1'b1;
    @(negedge clk);
    maskWr = 1'b0;
  endtask

  task automatic pulseClr();
    errClr = 1'b1;
    @(negedge clk);
    errClr = 1'b0;
    @(negedge clk);
  endtask

  // one frame of bits; bus data set at each rising edge, tx sampled before fall
  task automatic runFrame(input int nBits, input int fsAt, input int wrAt,
                          input logic [31:0] wrMask);
    frameTag++;
    for (int p = 0; p < nBits; p++) begin
      logic [7:0] v;
      v = rxPat(p / 8, frameTag);
      tdmClk = 1'b1; tdmFsync = (p == fsAt); tdmRxd = v[7 - (p % 8)];
      if (p == wrAt) begin
        writeMask(wrMask);
        repeat (5) @(negedge clk);
      end else begin
        repeat (6) @(negedge clk);
      end
      txOeSeen[p] = tdmTxOe;
      txDSeen[p]  = tdmTxd;
      tdmClk = 1'b0;
      repeat (6) @(negedge clk);
    end
  endtask

  task automatic checkRx(input string req, input int nSlots, input logic [31:0] mask);
    for (int s = 0; s < 32; s++) begin
      bit exp, got;
      exp = mask[s] && (s < nSlots);
      got = (gotTag[s] == frameTag);
      chk(got == exp, $sformatf("%s rx slot %0d presence", req, s), got, exp);
      if (exp && got)
        chk(gotByte[s] == rxPat(s, frameTag), $sformatf("%s rx slot %0d data", req, s),
            gotByte[s], rxPat(s, frameTag));
    end
  endtask

  task automatic checkTx(input string req, input int nSlots, input logic [31:0] mask);
    for (int s = 0; s < nSlots; s++) begin
      logic [7:0] oeBits, dBits, expD;
      for (int b = 0; b < 8; b++) begin
        oeBits[7 - b] = txOeSeen[s * 8 + b];
        dBits[7 - b]  = txDSeen[s * 8 + b];
      end
      expD = txPat(5'(s));
      chk(oeBits == {8{mask[s]}}, $sformatf("%s tx slot %0d enable", req, s),
          oeBits, {8{mask[s]}});
      if (mask[s])
        chk(dBits == expD, $sformatf("%s tx slot %0d data", req, s), dBits, expD);
    end
  endtask

  task automatic testReset();
    chk(rxValid == 1'b0, "R1 rxValid after reset", rxValid, 0);
    chk(tdmTxOe == 1'b0, "R1 txOe after reset", tdmTxOe, 0);
    chk(txReq == 1'b0, "R1 txReq after reset", txReq, 0);
    chk(frmErr == 1'b0, "R1 frmErr after reset", frmErr, 0);
    chk(rxOverrun == 1'b0, "R1 rxOverrun after reset", rxOverrun, 0);
    writeMask(32'hFFFF_FFFF);
    e1Mode = 1'b1;
    runFrame(256, -1, -1, '0);
    checkRx("R1 unsynced", 32, '0);
    checkTx("R1 unsynced", 32, '0);
  endtask

  task automatic testT1();
    logic [31:0] m;
    m = 32'h4080_0021;  // slots 0, 5, 23 and 30 (ignored in 24-slot mode)
    e1Mode = 1'b0;
    writeMask(m);
    runFrame(192, 0, -1, '0);
    runFrame(192, 0, -1, '0);
    checkRx("R3 R4 t1", 24, m);
    checkTx("R5 R6 t1", 24, m);
    chk(frmErr == 1'b0, "R2 t1 frame length", frmErr, 0);
  endtask

  task automatic testMaskChange();
    writeMask(32'h0000_0004);
    runFrame(192, 0, -1, '0);
    runFrame(192, 0, 10, 32'h0000_0008);
    checkRx("R7 old mask kept", 24, 32'h0000_0004);
    checkTx("R7 old mask kept", 24, 32'h0000_0004);
    runFrame(192, 0, -1, '0);
    checkRx("R7 new mask", 24, 32'h0000_0008);
    checkTx("R7 new mask", 24, 32'h0000_0008);
  endtask

  task automatic testE1();
    logic [31:0] m;
    m = 32'h8000_0002;  // slots 1 and 31
    e1Mode = 1'b1;
    writeMask(m);
    runFrame(256, 0, -1, '0);
    runFrame(256, 0, -1, '0);
    checkRx("R2 R3 e1", 32, m);
    checkTx("R5 R6 e1", 32, m);
    chk(frmErr == 1'b0, "R2 e1 frame length", frmErr, 0);
  endtask

  task automatic testFraming();
    writeMask(32'h0000_0011);
    runFrame(256, 0, -1, '0);
    runFrame(100, 0, -1, '0);
    chk(frmErr == 1'b0, "R8 no error before early sync", frmErr, 0);
    runFrame(256, 0, -1, '0);
    chk(frmErr == 1'b1, "R8 early sync flagged", frmErr, 1);
    checkRx("R8 realigned", 32, 32'h0000_0011);
    runFrame(256, 0, -1, '0);
    chk(frmErr == 1'b1, "R8 flag sticky", frmErr, 1);
    pulseClr();
    chk(frmErr == 1'b0, "R8 flag cleared", frmErr, 0);
  endtask

  task automatic testOverrun();
    writeMask(32'h0000_0006);
    autoAck = 1'b0;
    runFrame(256, 0, -1, '0);
    chk(rxValid == 1'b1, "R9 held byte valid", rxValid, 1);
    chk(rxSlot == 5'd1, "R9 first slot kept", rxSlot, 1);
    chk(rxData == rxPat(1, frameTag), "R9 first byte kept", rxData, rxPat(1, frameTag));
    chk(rxOverrun == 1'b1, "R9 overrun flagged", rxOverrun, 1);
    ackReq++;
    repeat (4) @(negedge clk);
    chk(rxValid == 1'b0, "R9 ack empties register", rxValid, 0);
    chk(rxOverrun == 1'b1, "R9 overrun sticky", rxOverrun, 1);
    pulseClr();
    chk(rxOverrun == 1'b0, "R9 overrun cleared", rxOverrun, 0);
    autoAck = 1'b1;
  endtask

  initial begin
    for (int s = 0; s < 32; s++) begin gotTag[s] = 0; gotByte[s] = '0; end
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    testReset();
    testT1();
    testMaskChange();
    testE1();
    testFraming();
    testOverrun();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors + 1, checks + 1);
      $finish;
    end
  end
endmodule